// File: doc/BRIEF.md
# Forward Command Decoder with Run-Length Expansion

This block is the receive side of a peripheral's forward channel on a bidirectional parallel link. The host presents a byte, pulls its strobe low, and waits for the peripheral's busy line to rise. The host then releases the strobe and waits for busy to fall again. A sideband acknowledge line, sampled with the byte, marks it as plain data (high) or as a command (low).

Commands either select a channel tag or load a run-length count. A channel command carries bit 7 set, and bits 6:0 become the tag attached to every data byte that follows. A count command carries bit 7 clear, and bits 6:0 give how many extra copies of the next data byte are emitted. Counts are accepted only when the run-length mode input is high.

Data leaves on a valid/ready stream that carries the byte and its channel tag. A beat completes on any clock edge where both `out_valid` and `out_ready` are high. While `out_ready` is low, the byte and tag hold still. Back-pressure reaches the host through busy, which stays high until every copy has drained. A single-cycle `chan_clear` pulse, given on a new link session or on termination, returns the tag to zero and drops any pending count.

Top module: `ecp_fwd_decoder`

## Requirements
- R1: Out of reset, `periph_busy`, `out_valid` and `proto_err` are 0 and the channel tag is 0.
- R2: If `host_strobe_n` is low while `periph_busy` is low, the byte is taken at that clock edge and `periph_busy` is 1 after it. `periph_busy` stays 1 until `host_strobe_n` is high and no copy remains to emit.
- R3: A byte taken with `host_ack`=1 and no pending count gives exactly one beat, whose `out_data` equals the byte. It appears the cycle after the byte is taken.
- R4: A byte taken with `host_ack`=0 and bit 7 = 1 gives no beat. It sets the tag shown on `out_chan` for later data to bits 6:0.
- R5: With `rle_mode`=1, a byte taken with `host_ack`=0 and bit 7 = 0 loads count C = bits 6:0. The next data byte is then emitted C+1 times, so 0 gives 1 beat and 127 gives 128 beats.
- R6: With `rle_mode`=0, a count command raises `proto_err` for exactly one cycle. It gives no beat, and the next data byte is emitted once.
- R7: A second count command before any data byte replaces the first.
- R8: A pending count is used by one data byte only, and the data byte after it is emitted once.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_chan` hold, and `periph_busy` stays 1.
- R10: A `chan_clear` pulse sets the tag to 0 and discards a pending count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rle_mode | input | 1 | 1 when run-length counts are permitted |
| chan_clear | input | 1 | Pulse: tag to 0, pending count dropped |
| host_strobe_n | input | 1 | Host strobe, low presents a byte (synchronous to clk) |
| host_ack | input | 1 | 1 = data byte, 0 = command byte |
| host_data | input | DW | Forward byte from host |
| periph_busy | output | 1 | Interlock reply to the host strobe |
| out_valid | output | 1 | Stream beat available |
| out_ready | input | 1 | Stream sink accepts beat |
| out_data | output | DW | Stream data byte |
| out_chan | output | DW-1 | Channel tag of the beat |
| proto_err | output | 1 | One-cycle pulse: count command outside run-length mode |

## Verification
Each byte is taken on the edge where the strobe is seen low, and `periph_busy` is high one cycle later. On that same cycle `proto_err` pulses or the first beat of the byte appears. After that, one beat completes on each edge where `out_ready` is high. The bench drives the strobe on a falling edge and samples busy, error and the first beat on the next falling edge. It then counts beats on falling edges until `out_valid` drops, and checks busy low on the falling edge after the last beat. The stall test holds `out_ready` low for several falling edges and compares the held values each time.

// File: rtl/ecp_fwd_pkg.sv
package ecp_fwd_pkg;
  typedef enum logic {HS_IDLE = 1'b0, HS_HOLD = 1'b1} hs_state_t;
endpackage

// File: rtl/ecp_fwd_strobe.sv
module ecp_fwd_strobe
  import ecp_fwd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  input  logic drain_empty,
  output logic take,
  output logic hold
);
  hs_state_t state_q;

  assign take = (state_q == HS_IDLE) && !strobe_n && drain_empty;
  assign hold = (state_q == HS_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
    end else begin
      unique case (state_q)
        HS_IDLE: if (take) state_q <= HS_HOLD;
        HS_HOLD: if (strobe_n) state_q <= HS_IDLE;
        default: state_q <= HS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecp_fwd_cmd.sv
module ecp_fwd_cmd #(
  parameter int DW = 8,
  localparam int AW = DW - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          host_ack,
  input  logic [DW-1:0] host_data,
  input  logic          rle_mode,
  input  logic          chan_clear,
  output logic [AW-1:0] chan_q,
  output logic [AW-1:0] pend_q,
  output logic          data_take,
  output logic          err_q
);
  logic is_cmd, is_addr, is_count;

  assign data_take = take && host_ack;
  assign is_cmd    = take && !host_ack;
  assign is_addr   = is_cmd && host_data[DW-1];
  assign is_count  = is_cmd && !host_data[DW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_q <= '0;
      pend_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= is_count && !rle_mode;
      if (chan_clear) begin
        chan_q <= '0;
        pend_q <= '0;
      end else begin
        if (is_addr) chan_q <= host_data[AW-1:0];
        if (is_count && rle_mode) pend_q <= host_data[AW-1:0];
        else if (data_take) pend_q <= '0;
      end
    end
  end
endmodule

// File: rtl/ecp_fwd_expand.sv
module ecp_fwd_expand #(
  parameter int DW = 8,
  localparam int AW = DW - 1,
  localparam int RW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_byte,
  input  logic [AW-1:0] load_count,
  input  logic [AW-1:0] load_chan,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [AW-1:0] out_chan,
  output logic          empty
);
  logic [RW-1:0] left_q;
  logic [DW-1:0] byte_q;
  logic [AW-1:0] chan_q;

  assign out_valid = (left_q != '0);
  assign empty     = !out_valid;
  assign out_data  = byte_q;
  assign out_chan  = chan_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      byte_q <= '0;
      chan_q <= '0;
    end else if (load) begin
      left_q <= RW'(load_count) + RW'(1);
      byte_q <= load_byte;
      chan_q <= load_chan;
    end else if (out_valid && out_ready) begin
      left_q <= left_q - RW'(1);
    end
  end
endmodule

// File: rtl/ecp_fwd_decoder.sv
module ecp_fwd_decoder #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rle_mode,
  input  logic          chan_clear,
  input  logic          host_strobe_n,
  input  logic          host_ack,
  input  logic [DW-1:0] host_data,
  output logic          periph_busy,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [DW-2:0] out_chan,
  output logic          proto_err
);
  localparam int AW = DW - 1;

  logic          take, hold, empty, data_take;
  logic [AW-1:0] chan_q, pend_q;

  ecp_fwd_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .strobe_n(host_strobe_n),
    .drain_empty(empty), .take(take), .hold(hold)
  );

  ecp_fwd_cmd #(.DW(DW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .take(take), .host_ack(host_ack),
    .host_data(host_data), .rle_mode(rle_mode), .chan_clear(chan_clear),
    .chan_q(chan_q), .pend_q(pend_q), .data_take(data_take), .err_q(proto_err)
  );

  ecp_fwd_expand #(.DW(DW)) u_expand (
    .clk(clk), .rst_n(rst_n), .load(data_take), .load_byte(host_data),
    .load_count(pend_q), .load_chan(chan_q), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan),
    .empty(empty)
  );

  assign periph_busy = hold || !empty;
endmodule

// File: rtl/ecp_fwd_decoder_chk.sv
module ecp_fwd_decoder_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rle_mode,
  input logic          host_strobe_n,
  input logic          host_ack,
  input logic [DW-1:0] host_data,
  input logic          periph_busy,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [DW-2:0] out_chan,
  input logic          proto_err
);
  AST_TAKE_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!periph_busy && !host_strobe_n) |=> periph_busy); // R2

  AST_DATA_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!periph_busy && !host_strobe_n && host_ack) |=> (out_valid && out_data == $past(host_data))); // R3

  AST_CMD_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!periph_busy && !host_strobe_n && !host_ack) |=> !out_valid); // R4

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(!rle_mode && !host_ack && !host_strobe_n && !periph_busy && !host_data[DW-1])); // R6

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan))); // R9

  AST_BUSY_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> periph_busy); // R9
endmodule

bind ecp_fwd_decoder ecp_fwd_decoder_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rle_mode(rle_mode), .host_strobe_n(host_strobe_n),
  .host_ack(host_ack), .host_data(host_data), .periph_busy(periph_busy),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_chan(out_chan), .proto_err(proto_err)
);

// File: tb/ecp_fwd_decoder_bench.sv
module ecp_fwd_decoder_bench;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rle_mode = 1'b1;
  logic          chan_clear = 1'b0;
  logic          host_strobe_n = 1'b1;
  logic          host_ack = 1'b1;
  logic [DW-1:0] host_data = '0;
  logic          out_ready = 1'b1;
  logic          periph_busy, out_valid, proto_err;
  logic [DW-1:0] out_data;
  logic [DW-2:0] out_chan;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ecp_fwd_decoder #(.DW(DW)) u_ecp_fwd_decoder (
    .clk(clk), .rst_n(rst_n), .rle_mode(rle_mode), .chan_clear(chan_clear),
    .host_strobe_n(host_strobe_n), .host_ack(host_ack), .host_data(host_data),
    .periph_busy(periph_busy), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_chan(out_chan), .proto_err(proto_err)
  );

  // vector: rle, ack, byte, beats, chan, err
  localparam int NV = 17;
  localparam logic [25:0] VEC [0:NV-1] = '{
    {1'b1, 1'b1, 8'h11, 8'd1,   7'd0,   1'b0},  // R3
    {1'b1, 1'b0, 8'h85, 8'd0,   7'd0,   1'b0},  // R4
    {1'b1, 1'b1, 8'h22, 8'd1,   7'd5,   1'b0},  // R4
    {1'b1, 1'b0, 8'h03, 8'd0,   7'd0,   1'b0},  // R5
    {1'b1, 1'b1, 8'h33, 8'd4,   7'd5,   1'b0},  // R5
    {1'b1, 1'b1, 8'h44, 8'd1,   7'd5,   1'b0},  // R8
    {1'b1, 1'b0, 8'h00, 8'd0,   7'd0,   1'b0},  // R5
    {1'b1, 1'b1, 8'h55, 8'd1,   7'd5,   1'b0},  // R5
    {1'b1, 1'b0, 8'h10, 8'd0,   7'd0,   1'b0},  // R7
    {1'b1, 1'b0, 8'h02, 8'd0,   7'd0,   1'b0},  // R7
    {1'b1, 1'b1, 8'h66, 8'd3,   7'd5,   1'b0},  // R7
    {1'b1, 1'b0, 8'h7F, 8'd0,   7'd0,   1'b0},  // R5
    {1'b1, 1'b1, 8'h77, 8'd128, 7'd5,   1'b0},  // R5
    {1'b1, 1'b0, 8'hFF, 8'd0,   7'd0,   1'b0},  // R4
    {1'b1, 1'b1, 8'h88, 8'd1,   7'd127, 1'b0},  // R4
    {1'b0, 1'b0, 8'h05, 8'd0,   7'd0,   1'b1},  // R6
    {1'b0, 1'b1, 8'h99, 8'd1,   7'd127, 1'b0}   // R6
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives one byte and drains its beats (out_ready must be 1).
  task automatic xfer(input bit rle, input bit ack, input logic [7:0] b,
                      input int beats, input int ch, input bit err, input string req);
    int n = 0;
    @(negedge clk);
    rle_mode = rle; host_ack = ack; host_data = b; host_strobe_n = 1'b0;
    @(negedge clk);
    chk(periph_busy == 1'b1, "R2", periph_busy, 1);
    chk(proto_err == err, req, proto_err, err);
    host_strobe_n = 1'b1;
    for (int k = 0; k < 300 && out_valid; k++) begin
      chk(out_data == b && int'(out_chan) == ch, req, out_data, b);
      n++;
      @(negedge clk);
    end
    chk(n == beats, req, n, beats);
    if (periph_busy) @(negedge clk);
    chk(periph_busy == 1'b0, "R2", periph_busy, 0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!periph_busy && !out_valid && !proto_err, "R1", {periph_busy, out_valid, proto_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!periph_busy && !out_valid, "R1", periph_busy, 0);
    xfer(1'b1, 1'b1, 8'h01, 1, 0, 1'b0, "R1");

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v = VEC[i];
      string req;
      req = $sformatf("vec%0d", i);
      xfer(v[25], v[24], v[23:16], int'(v[15:8]), int'(v[7:1]), v[0], req);
    end

    // R10: clear drops tag and pending count
    rle_mode = 1'b1;
    xfer(1'b1, 1'b0, 8'h86, 0, 0, 1'b0, "R10");
    xfer(1'b1, 1'b0, 8'h04, 0, 0, 1'b0, "R10");
    @(negedge clk); chan_clear = 1'b1;
    @(negedge clk); chan_clear = 1'b0;
    xfer(1'b1, 1'b1, 8'hC3, 1, 0, 1'b0, "R10");

    // R9: stall keeps beat and busy
    xfer(1'b1, 1'b0, 8'h01, 0, 0, 1'b0, "R9");
    out_ready = 1'b0;
    @(negedge clk);
    host_ack = 1'b1; host_data = 8'hAB; host_strobe_n = 1'b0;
    @(negedge clk);
    host_strobe_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(out_valid && out_data == 8'hAB && out_chan == '0, "R9", out_data, 8'hAB);
      chk(periph_busy == 1'b1, "R9", periph_busy, 1);
    end
    out_ready = 1'b1;
    begin
      int n = 0;
      for (int k = 0; k < 10 && out_valid; k++) begin n++; @(negedge clk); end
      chk(n == 2, "R9", n, 2);
    end
    if (periph_busy) @(negedge clk);
    chk(!periph_busy, "R2", periph_busy, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule